// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

The block turns the two phase signals of an incremental rotary or linear encoder into a signed-free position count held in a register. Both phase inputs pass through synchronisers, and their edges then drive a counter. A two-bit mode field picks the decoding: a free-running count on the system clock, double-rate decoding from either phase alone, or quadruple-rate decoding from both phases. The count moves only while an enable bit is set, and it stays between zero and a programmable ceiling, wrapping in both directions.

Software reaches the block through a simple synchronous register bus: an address, a write strobe, write data and combinational read data. It can load the count directly, program the ceiling either at once or through a buffer that is copied over on the next update event, and force such an event by a self-clearing strobe. A read-only status bit shows the direction of the most recent step.

Top module: `qenc_counter`

## Requirements
- R1: After reset the count reads 0, the control and mode registers read 0, and the ceiling reads 2^CNT_W-1.
- R2: Register map on a 3-bit word address: 0 control (bit0 enable, bit1 preload enable, bit2 direction, read-only); 1 mode (bits 1:0); 2 event (bit0 writes 1 to force an update, always reads 0); 3 count; 4 ceiling (reads the most recently accepted ceiling write). Unmapped addresses read 0.
- R3: Mode 0 adds one to the count on every clock while enabled, and the phase inputs have no effect on it.
- R4: While the enable bit is 0 the count holds its value.
- R5: Mode 1 steps on each edge of phase A: up when the new A level differs from B, down when it equals B. Edges of B alone do not step.
- R6: Mode 2 steps on each edge of phase B: up when the new B level equals A, down when it differs. Edges of A alone do not step.
- R7: Mode 3 steps on every edge of either phase; the sequence (A,B) = 00,10,11,01 counts up and its reverse counts down. A clock in which both synchronised phases change does not step.
- R8: A step up from the ceiling gives 0 and a step down from 0 gives the ceiling; each such wrap raises an update event.
- R9: The direction bit reads 1 after a down step and 0 after an up step.
- R10: With preload disabled a ceiling write takes effect in the next cycle; with preload enabled the active ceiling changes only on an update event (event-register strobe or wrap).
- R11: A ceiling write whose data exceeds 2^CNT_W-1 is ignored.
- R12: A count write in the same cycle as a step wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder phase A, asynchronous |
| enc_b_i | input | 1 | Encoder phase B, asynchronous |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |

## Verification
The assertions take for granted that a phase input holds each level long enough for the synchroniser chain and edge detector to see it, so that every physical transition reaches the decoder as a single one-cycle edge. The stimulus changes one phase at a time (except in the deliberate simultaneous-change case) and then holds the levels for four clocks before the next change or a register read. Enable, mode and count are only reconfigured through the bus while the counter is disabled, apart from the single case that checks a count write racing a step.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } qenc_mode_e;

  localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EVT  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CNT  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_CEIL = 3'd4;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign edge_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  qenc_mode_e mode_i,
  input  logic       lvl_a_i,
  input  logic       lvl_b_i,
  input  logic       edge_a_i,
  input  logic       edge_b_i,
  output logic       up_o,
  output logic       dn_o
);
  always_comb begin
    up_o = 1'b0;
    dn_o = 1'b0;
    unique case (mode_i)
      MODE_CLK: up_o = 1'b1;
      MODE_X2A: if (edge_a_i) begin
        up_o = lvl_a_i != lvl_b_i;
        dn_o = lvl_a_i == lvl_b_i;
      end
      MODE_X2B: if (edge_b_i) begin
        up_o = lvl_b_i == lvl_a_i;
        dn_o = lvl_b_i != lvl_a_i;
      end
      MODE_X4: if (edge_a_i ^ edge_b_i) begin
        // single-phase edge only; both changing is an illegal jump
        if (edge_a_i) begin
          up_o = lvl_a_i != lvl_b_i;
          dn_o = lvl_a_i == lvl_b_i;
        end else begin
          up_o = lvl_b_i == lvl_a_i;
          dn_o = lvl_b_i != lvl_a_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             ceil_we_i,
  input  logic [CNT_W-1:0] ceil_wdata_i,
  input  logic             preload_i,
  input  logic             ug_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ceil_buf_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q, ceil_q, buf_q;
  logic             dir_q, step, top_hit, bot_hit, uev;

  assign top_hit = cnt_q >= ceil_q;
  assign bot_hit = cnt_q == '0;
  assign step    = en_i && (up_i || dn_i) && !cnt_we_i;
  assign uev     = ug_i || (step && (up_i ? top_hit : bot_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (cnt_we_i) begin
      cnt_q <= cnt_wdata_i;
    end else if (step) begin
      dir_q <= dn_i;
      if (up_i) cnt_q <= top_hit ? '0 : cnt_q + 1'b1;
      else      cnt_q <= bot_hit ? ceil_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '1;
      ceil_q <= '1;
    end else begin
      if (ceil_we_i) buf_q <= ceil_wdata_i;
      if (ceil_we_i && !preload_i) ceil_q <= ceil_wdata_i;
      else if (uev)                ceil_q <= buf_q;
    end
  end

  assign cnt_o      = cnt_q;
  assign ceil_buf_o = buf_q;
  assign dir_o      = dir_q;

  // R4
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !cnt_we_i |=> $stable(cnt_q));
  // R12
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_q == $past(cnt_wdata_i));
  // R8
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && up_i && !cnt_we_i && cnt_q == ceil_q |=> cnt_q == '0);
  // R8
  wrap_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dn_i && !cnt_we_i && cnt_q == '0 |=> cnt_q == $past(ceil_q));
  // R10
  ceil_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ceil_we_i && !preload_i |=> ceil_q == $past(ceil_wdata_i));
  // R10
  ceil_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i && !ug_i && !en_i |=> $stable(ceil_q));
  // R9
  dir_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dn_i && !cnt_we_i |=> dir_q);
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] CEIL_MAX = DATA_W'({CNT_W{1'b1}});

  logic [1:0] raw, lvl, edg;
  logic       en_q, pre_q, up, dn, dir, ug, cnt_we, ceil_we;
  qenc_mode_e mode_q;
  logic [CNT_W-1:0] cnt, ceil_buf;

  assign raw = {enc_b_i, enc_a_i};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    qenc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .lvl_o (lvl[i]),
      .edge_o(edg[i])
    );
  end

  qenc_decode i_decode (
    .mode_i  (mode_q),
    .lvl_a_i (lvl[0]),
    .lvl_b_i (lvl[1]),
    .edge_a_i(edg[0]),
    .edge_b_i(edg[1]),
    .up_o    (up),
    .dn_o    (dn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b0;
      mode_q <= MODE_CLK;
    end else if (we_i) begin
      if (addr_i == REG_CTRL) begin
        en_q  <= wdata_i[0];
        pre_q <= wdata_i[1];
      end
      if (addr_i == REG_MODE) mode_q <= qenc_mode_e'(wdata_i[1:0]);
    end
  end

  assign ug      = we_i && addr_i == REG_EVT && wdata_i[0];
  assign cnt_we  = we_i && addr_i == REG_CNT;
  assign ceil_we = we_i && addr_i == REG_CEIL && wdata_i <= CEIL_MAX;

  qenc_core #(.CNT_W(CNT_W)) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .up_i        (up),
    .dn_i        (dn),
    .cnt_we_i    (cnt_we),
    .cnt_wdata_i (wdata_i[CNT_W-1:0]),
    .ceil_we_i   (ceil_we),
    .ceil_wdata_i(wdata_i[CNT_W-1:0]),
    .preload_i   (pre_q),
    .ug_i        (ug),
    .cnt_o       (cnt),
    .ceil_buf_o  (ceil_buf),
    .dir_o       (dir)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: rdata_o[2:0] = {dir, pre_q, en_q};
      REG_MODE: rdata_o[1:0] = mode_q;
      REG_CNT:  rdata_o      = DATA_W'(cnt);
      REG_CEIL: rdata_o      = DATA_W'(ceil_buf);
      default:  rdata_o      = '0;
    endcase
  end

  // R3
  clk_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_CLK |-> up && !dn);
  // R7
  x4_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_X4 && edg[0] && edg[1] |-> !up && !dn);
  // R5
  x2a_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_X2A && !edg[0] |-> !up && !dn);
  // R6
  x2b_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_X2B && !edg[1] |-> !up && !dn);
  // R7
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({up, dn}));
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_a_i = 1'b0, enc_b_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event rd_ev;

  always #5 clk_i = ~clk_i;

  qenc_counter i_qenc_counter (
    .clk_i, .rst_ni, .enc_a_i, .enc_b_i, .addr_i, .we_i, .wdata_i, .rdata_o
  );

  // monitor: pops expected items and compares against the read port
  initial forever begin
    @(rd_ev);
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata_o !== it.exp) begin
        errors++;
        $display("FAIL %s addr %0d actual %0d expected %0d", it.tag, it.addr, rdata_o, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    ->rd_ev;
    #2;
  endtask

  task automatic run(input int n, input logic [31:0] base);
    wr(3'd0, base | 32'd1);
    repeat (n - 1) @(posedge clk_i);
    wr(3'd0, base);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk_i);
    enc_a_i = a; enc_b_i = b;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    expect_rd(3'd0, 0, "R1 ctrl");
    expect_rd(3'd1, 0, "R1 mode");
    expect_rd(3'd3, 0, "R1 count");
    expect_rd(3'd4, 32'hFFFF, "R1 ceiling");
    expect_rd(3'd7, 0, "R2 unmapped");

    // R3: mode 0, six steps while phase A toggles
    fork
      run(6, 0);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk_i); enc_a_i = ~enc_a_i;
      end
    join
    expect_rd(3'd3, 6, "R3 clock count");
    // R4: frozen while disabled
    repeat (10) @(negedge clk_i);
    expect_rd(3'd3, 6, "R4 freeze");

    // R8: wrap up, ceiling 9
    wr(3'd4, 9);
    wr(3'd3, 7);
    run(4, 0);
    expect_rd(3'd3, 1, "R8 wrap up");

    // R10: preload on
    wr(3'd0, 2);
    wr(3'd4, 3);
    expect_rd(3'd4, 3, "R2 ceiling readback");
    wr(3'd3, 8);
    run(2, 2);
    expect_rd(3'd3, 0, "R10 buffered ceiling");
    run(4, 2);
    expect_rd(3'd3, 0, "R8 wrap loads buffer");
    wr(3'd4, 5);
    wr(3'd2, 1);
    expect_rd(3'd2, 0, "R2 event reads 0");
    wr(3'd3, 4);
    run(2, 2);
    expect_rd(3'd3, 0, "R10 forced update");
    // R10: preload off
    wr(3'd0, 0);
    wr(3'd4, 2);
    wr(3'd3, 1);
    run(2, 0);
    expect_rd(3'd3, 0, "R10 immediate ceiling");
    // R11
    wr(3'd4, 32'h0001_0000);
    expect_rd(3'd4, 2, "R11 oversize ignored");

    // R12
    wr(3'd4, 1000);
    wr(3'd0, 1);
    wr(3'd3, 500);
    wr(3'd0, 0);
    expect_rd(3'd3, 501, "R12 write priority");
    expect_rd(3'd0, 0, "R9 dir up");

    // R5: x2 on A
    enc_a_i = 1'b0; enc_b_i = 1'b0;
    repeat (4) @(negedge clk_i);
    wr(3'd1, 1);
    expect_rd(3'd1, 1, "R2 mode readback");
    wr(3'd3, 10);
    wr(3'd0, 1);
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    expect_rd(3'd3, 12, "R5 A leads");
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    expect_rd(3'd3, 10, "R5 B leads");
    expect_rd(3'd0, 5, "R9 dir down");

    // R6: x2 on B
    wr(3'd0, 0);
    wr(3'd1, 2);
    wr(3'd3, 10);
    wr(3'd0, 1);
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    expect_rd(3'd3, 12, "R6 A leads");
    set_ab(0, 1);
    expect_rd(3'd3, 11, "R6 down step");
    set_ab(0, 0);
    expect_rd(3'd3, 12, "R6 up step");

    // R7: x4
    wr(3'd0, 0);
    wr(3'd1, 3);
    wr(3'd3, 10);
    wr(3'd0, 1);
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    expect_rd(3'd3, 14, "R7 forward");
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    expect_rd(3'd3, 10, "R7 reverse");
    set_ab(1, 1); set_ab(0, 0);
    expect_rd(3'd3, 10, "R7 jump ignored");

    // R8: wrap down and back
    wr(3'd3, 0);
    set_ab(0, 1);
    expect_rd(3'd3, 1000, "R8 wrap down");
    set_ab(0, 0);
    expect_rd(3'd3, 0, "R8 wrap up x4");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule